// File: doc/BRIEF.md
# Reduced-State Sliding-Block Viterbi Detector for Four-Level PAM

This block turns equalised, quantised receive samples from a channel with intersymbol interference back into four-level PAM symbol decisions. It runs a trellis with only two states, one for each half of a set-partitioned alphabet. The interference left over from the previous two symbols is cancelled separately on each survivor path, using that path's own earlier decisions as feedback.

Decoding happens in independent blocks of eight symbols. Samples go into a ring buffer. Once eight new samples have been collected, the detector runs the trellis one step per clock. It starts at a programmable number of older samples, which serve only to warm up the metrics, and ends at the newest sample. It then emits the eight newest decisions together as one beat. While the block is running, the sample input is held off.

Top module: `rsvd_viterbi_det`

## Requirements
- R1: Each decision is a 2-bit Gray code: level -3 is 00, -1 is 01, +1 is 11, +3 is 10. In `dec_syms`, symbol i of the block sits at bits [2i+1:2i], and i=0 is the earliest sample.
- R2: When `tap_h1` and `tap_h2` are zero and `tap_h0` is positive, every decision equals slicing the sample to the nearest of -3·h0, -1·h0, +1·h0 and +3·h0 (for samples that are not on a midpoint).
- R3: With `sync_len` zero, noiseless samples x_k = h0·a_k + h1·a_{k-1} + h2·a_{k-2} are decoded back to exactly a_0..a_7. Symbols before the block count as zero, and h0 is non-zero.
- R4: `smp_ready` stays high while a block is being collected. After the eighth sample is accepted it is low for P+9 cycles, where P is the prefix length. `dec_valid` is high for exactly the one cycle in which `smp_ready` returns high.
- R5: The prefix length P is the smallest of `sync_len`, MAX_SYNC, and the number of samples accepted since reset before the current block.
- R6: Prefix samples only warm up the detector. The output beat holds the decisions for the eight newest samples and no prefix decision.
- R7: The path metrics are renormalised after every step so that one of them is zero. They never reach their all-ones value, even with full-scale samples.
- R8: During and right after reset, `smp_ready` is 1, `dec_valid` is 0 and `dec_syms` is 0. A partly collected block is discarded and the prefix history is cleared.
- R9: `dec_syms` changes only in a cycle where `dec_valid` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample valid |
| smp_data | input | SW | Signed equalised sample |
| smp_ready | output | 1 | Sample accepted while high |
| tap_h0 | input | TW | Signed main-cursor tap |
| tap_h1 | input | TW | Signed first post-cursor tap |
| tap_h2 | input | TW | Signed second post-cursor tap |
| sync_len | input | clog2(MAX_SYNC+1) | Requested warm-up prefix length |
| dec_valid | output | 1 | One-cycle pulse marking a new output beat |
| dec_syms | output | 2*BLK | Eight Gray-coded decisions, earliest in the low bits |

## Verification
The assertions assume that the taps and `sync_len` stay constant from the first sample of a block until its beat is produced. They also assume that the sample and tap widths keep every branch metric far below the metric range. The bench changes taps and `sync_len` only while `smp_ready` is high and before the first sample of a new block. It keeps every sample inside the signed 8-bit range. Its decoding checks keep slicing noise strictly below h0, and they use noiseless interference only in blocks whose prefix is zero, so the expected decisions are unique.

// File: rtl/rsvd_pkg.sv
package rsvd_pkg;
  typedef logic [1:0] sym_t;

  // Gray code to amplitude level
  function automatic logic signed [2:0] sym_lvl(sym_t c);
    case (c)
      2'b00:   return -3'sd3;
      2'b01:   return -3'sd1;
      2'b11:   return  3'sd1;
      default: return  3'sd3;
    endcase
  endfunction

  // Member m of subset j: subset 0 = {-3,+1}, subset 1 = {-1,+3}; m=0 is the lower level
  function automatic sym_t subset_sym(logic j, logic m);
    case ({j, m})
      2'b00:   return 2'b00;
      2'b01:   return 2'b11;
      2'b10:   return 2'b01;
      default: return 2'b10;
    endcase
  endfunction
endpackage

// File: rtl/rsvd_smpbuf.sv
module rsvd_smpbuf #(
  parameter int W  = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rsvd_acs.sv
module rsvd_acs import rsvd_pkg::*; #(
  parameter int SW = 8,
  parameter int TW = 6,
  parameter int MW = 26
) (
  input  logic signed [SW-1:0] smp,
  input  logic signed [TW-1:0] h0,
  input  logic signed [TW-1:0] h1,
  input  logic signed [TW-1:0] h2,
  input  logic [1:0][MW-1:0]   pm,
  input  logic [1:0][2:0]      fb1,
  input  logic [1:0][2:0]      fb2,
  output logic [1:0][MW-1:0]   pm_nxt,
  output sym_t [1:0]           sym,
  output logic [1:0]           pred
);
  localparam int EW  = ((SW > TW + 5) ? SW : TW + 5) + 1;
  localparam int QW  = 2 * EW;
  localparam int MW1 = MW + 1;

  function automatic logic signed [EW-1:0] mulv(logic signed [TW-1:0] h, logic signed [2:0] a);
    return EW'(h) * EW'(a);
  endfunction

  logic signed [1:0][EW-1:0] isi;
  logic signed [EW-1:0]      e0, e1;
  logic [QW-1:0]             q0, q1;
  logic [1:0][1:0][QW-1:0]   bm;     // [pred state][next state]
  sym_t [1:0][1:0]           bsym;
  logic [MW1-1:0]            acc0, acc1, mn;
  logic [1:0][MW1-1:0]       win, dif;

  always_comb begin
    // Per-survivor ISI cancellation, then the best member of each subset
    for (int s = 0; s < 2; s++) begin
      isi[s] = mulv(h1, $signed(fb1[s])) + mulv(h2, $signed(fb2[s]));
      for (int j = 0; j < 2; j++) begin
        e0 = EW'(smp) - isi[s] - mulv(h0, sym_lvl(subset_sym(j[0], 1'b0)));
        e1 = EW'(smp) - isi[s] - mulv(h0, sym_lvl(subset_sym(j[0], 1'b1)));
        q0 = QW'(e0) * QW'(e0);
        q1 = QW'(e1) * QW'(e1);
        if (q1 < q0) begin
          bm[s][j]   = q1;
          bsym[s][j] = subset_sym(j[0], 1'b1);
        end else begin
          bm[s][j]   = q0;
          bsym[s][j] = subset_sym(j[0], 1'b0);
        end
      end
    end
    // Add-compare-select, ties to substate 0
    for (int j = 0; j < 2; j++) begin
      acc0    = {1'b0, pm[0]} + MW1'(bm[0][j]);
      acc1    = {1'b0, pm[1]} + MW1'(bm[1][j]);
      pred[j] = (acc1 < acc0);
      win[j]  = pred[j] ? acc1 : acc0;
      sym[j]  = bsym[pred[j]][j];
    end
    // Renormalise and saturate
    mn = (win[1] < win[0]) ? win[1] : win[0];
    for (int j = 0; j < 2; j++) begin
      dif[j]    = win[j] - mn;
      pm_nxt[j] = dif[j][MW] ? '1 : dif[j][MW-1:0];
    end
  end
endmodule

// File: rtl/rsvd_surv.sv
module rsvd_surv import rsvd_pkg::*; #(
  parameter int BLK = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    init,
  input  logic                    step,
  input  sym_t [1:0]              sym,
  input  logic [1:0]              pred,
  output logic [1:0][2:0]         fb1,
  output logic [1:0][2:0]         fb2,
  output logic [1:0][2*BLK-1:0]   path_nxt
);
  logic [1:0][2*BLK-1:0] path;

  always_comb begin
    for (int j = 0; j < 2; j++)
      path_nxt[j] = {sym[j], path[pred[j]][2*BLK-1:2]};
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      path <= '0;
      fb1  <= '0;
      fb2  <= '0;
    end else if (step) begin
      for (int j = 0; j < 2; j++) begin
        path[j] <= path_nxt[j];
        fb1[j]  <= sym_lvl(sym[j]);
        fb2[j]  <= fb1[pred[j]];
      end
    end
  end
endmodule

// File: rtl/rsvd_viterbi_det.sv
module rsvd_viterbi_det import rsvd_pkg::*; #(
  parameter int SW       = 8,
  parameter int TW       = 6,
  parameter int BLK      = 8,
  parameter int MAX_SYNC = 24,
  localparam int LW      = $clog2(MAX_SYNC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_data,
  output logic                 smp_ready,
  input  logic signed [TW-1:0] tap_h0,
  input  logic signed [TW-1:0] tap_h1,
  input  logic signed [TW-1:0] tap_h2,
  input  logic [LW-1:0]        sync_len,
  output logic                 dec_valid,
  output logic [2*BLK-1:0]     dec_syms
);
  localparam int AW = $clog2(MAX_SYNC + BLK);
  localparam int NW = $clog2(MAX_SYNC + BLK + 1);
  localparam int FW = (BLK > 1) ? $clog2(BLK) : 1;
  localparam int EW = ((SW > TW + 5) ? SW : TW + 5) + 1;
  localparam int MW = 2 * EW + 2;

  typedef enum logic {ST_FILL, ST_RUN} st_t;

  st_t                   state;
  logic [FW-1:0]         fcnt;
  logic [AW-1:0]         wr_ptr, rd_ptr;
  logic [LW-1:0]         hist, pre, hist_nxt;
  logic [NW-1:0]         nsteps, issue_cnt, step_cnt, n_blk;
  logic                  step_vld, rd_en, wr_en, last_in, best;
  logic [SW-1:0]         rd_data;
  logic [1:0][MW-1:0]    pm, pm_nxt;
  sym_t [1:0]            sym;
  logic [1:0]            pred;
  logic [1:0][2:0]       fb1, fb2;
  logic [1:0][2*BLK-1:0] path_nxt;

  assign smp_ready = (state == ST_FILL);
  assign wr_en     = smp_ready && smp_valid;
  assign last_in   = wr_en && (fcnt == FW'(BLK - 1));
  assign rd_en     = (state == ST_RUN) && (issue_cnt < nsteps);
  assign pre       = (sync_len < hist) ? sync_len : hist;
  assign n_blk     = NW'(pre) + NW'(BLK);
  assign hist_nxt  = (int'(hist) + BLK >= MAX_SYNC) ? LW'(MAX_SYNC) : LW'(int'(hist) + BLK);
  assign best      = (pm_nxt[1] < pm_nxt[0]);

  rsvd_smpbuf #(.W(SW), .AW(AW)) buf_i (
    .clk(clk), .we(wr_en), .waddr(wr_ptr), .wdata(smp_data),
    .re(rd_en), .raddr(rd_ptr), .rdata(rd_data)
  );

  rsvd_acs #(.SW(SW), .TW(TW), .MW(MW)) acs_i (
    .smp($signed(rd_data)), .h0(tap_h0), .h1(tap_h1), .h2(tap_h2),
    .pm(pm), .fb1(fb1), .fb2(fb2), .pm_nxt(pm_nxt), .sym(sym), .pred(pred)
  );

  rsvd_surv #(.BLK(BLK)) surv_i (
    .clk(clk), .rst(rst), .init(last_in), .step(step_vld),
    .sym(sym), .pred(pred), .fb1(fb1), .fb2(fb2), .path_nxt(path_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FILL;
      fcnt      <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      hist      <= '0;
      nsteps    <= '0;
      issue_cnt <= '0;
      step_cnt  <= '0;
      step_vld  <= 1'b0;
      pm        <= '0;
      dec_valid <= 1'b0;
      dec_syms  <= '0;
    end else begin
      dec_valid <= 1'b0;
      step_vld  <= rd_en;
      case (state)
        ST_FILL: begin
          if (wr_en) begin
            wr_ptr <= wr_ptr + AW'(1);
            fcnt   <= last_in ? '0 : fcnt + FW'(1);
            if (last_in) begin
              state     <= ST_RUN;
              nsteps    <= n_blk;
              rd_ptr    <= wr_ptr + AW'(1) - AW'(n_blk);
              issue_cnt <= '0;
              step_cnt  <= '0;
              pm        <= '0;
              hist      <= hist_nxt;
            end
          end
        end
        default: begin
          if (rd_en) begin
            rd_ptr    <= rd_ptr + AW'(1);
            issue_cnt <= issue_cnt + NW'(1);
          end
          if (step_vld) begin
            pm       <= pm_nxt;
            step_cnt <= step_cnt + NW'(1);
            if (step_cnt == nsteps - NW'(1)) begin
              dec_valid <= 1'b1;
              dec_syms  <= path_nxt[best];
              state     <= ST_FILL;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rsvd_viterbi_det_chk.sv
module rsvd_viterbi_det_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic          dec_valid,
  input logic [DW-1:0] dec_syms,
  input logic          step_vld,
  input logic          pm_any_zero,
  input logic          pm_at_max
);
  // R4: ready only drops after a sample was taken
  assert_ready_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(smp_ready) |-> $past(smp_valid));

  // R4: a beat is a single-cycle pulse
  assert_dec_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  // R4: the beat coincides with ready coming back
  assert_dec_at_resume_R4: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (smp_ready && !$past(smp_ready)));

  // R7: after each trellis step one metric is zero
  assert_renorm_R7: assert property (@(posedge clk) disable iff (rst)
    $past(step_vld) |-> pm_any_zero);

  // R7: metrics never reach saturation
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    !pm_at_max);

  // R9: decisions hold between beats
  assert_dec_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> $stable(dec_syms));
endmodule

bind rsvd_viterbi_det rsvd_viterbi_det_chk #(.DW(2*BLK)) chk_i (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .dec_valid(dec_valid), .dec_syms(dec_syms), .step_vld(step_vld),
  .pm_any_zero((pm[0] == '0) || (pm[1] == '0)),
  .pm_at_max((&pm[0]) || (&pm[1]))
);

// File: tb/rsvd_viterbi_det_tb_top.sv
module rsvd_viterbi_det_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8, TW = 6, BLK = 8, MAX_SYNC = 24, LW = 5;
  localparam int NV = 8;

  typedef struct packed {
    int h0; int h1; int h2; int sync; int nz; logic [15:0] codes;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8,   0,  0,  6, 3, 16'h1B4E},
    '{10,  0,  0,  4, 4, 16'hE4C1},
    '{8,   3, -2,  0, 0, 16'h9A36},
    '{12,  0,  0, 20, 5, 16'h55F0},
    '{6,  -3,  2,  0, 0, 16'hC3A5},
    '{16,  0,  0, 31, 7, 16'h0F72},
    '{20,  0,  0,  2, 9, 16'hB1D8},
    '{8,   4,  3,  0, 0, 16'h6E29}
  };

  logic clk = 1'b0, rst = 1'b1, smp_valid = 1'b0;
  logic signed [SW-1:0] smp_data = '0;
  logic signed [TW-1:0] tap_h0 = '0, tap_h1 = '0, tap_h2 = '0;
  logic [LW-1:0] sync_len = '0;
  logic smp_ready, dec_valid;
  logic [2*BLK-1:0] dec_syms;

  int n_chk = 0, n_err = 0, hist = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsvd_viterbi_det #(.SW(SW), .TW(TW), .BLK(BLK), .MAX_SYNC(MAX_SYNC)) dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .tap_h0(tap_h0), .tap_h1(tap_h1), .tap_h2(tap_h2),
    .sync_len(sync_len), .dec_valid(dec_valid), .dec_syms(dec_syms)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'b00: return -3;
      2'b01: return -1;
      2'b11: return 1;
      default: return 3;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    hist = 0;
  endtask

  // Sends one block of samples; returns low-ready cycle count and the beat seen
  task automatic send_block(input vec_t v, input bit gaps, output int low, output bit gv,
                            output logic [15:0] got);
    int a [BLK];
    int x;
    @(negedge clk);
    tap_h0 = TW'(v.h0); tap_h1 = TW'(v.h1); tap_h2 = TW'(v.h2); sync_len = LW'(v.sync);
    for (int i = 0; i < BLK; i++) begin
      a[i] = lvl(v.codes[2*i +: 2]);
      x = v.h0 * a[i] + (i >= 1 ? v.h1 * a[i-1] : 0) + (i >= 2 ? v.h2 * a[i-2] : 0)
          + ((i % 3) - 1) * v.nz;
      if (gaps && (i % 3 == 1)) begin
        smp_valid = 1'b0;
        @(negedge clk);
      end
      smp_valid = 1'b1;
      smp_data  = SW'(x);
      @(posedge clk);
      @(negedge clk);
      smp_valid = 1'b0;
    end
    low = 1;
    while (!smp_ready && low < 200) begin
      @(negedge clk);
      if (!smp_ready) low++;
    end
    gv  = dec_valid;
    got = dec_syms;
  endtask

  initial begin
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int low, pre;
    bit gv;
    logic [15:0] got, held;
    vec_t v;

    do_reset();
    @(negedge clk);
    // R8: reset state
    check(smp_ready == 1'b1, "R8 ready after reset", int'(smp_ready), 1);
    check(dec_valid == 1'b0, "R8 dec_valid after reset", int'(dec_valid), 0);
    check(dec_syms == '0, "R8 dec_syms after reset", int'(dec_syms), 0);

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      pre = v.sync;
      if (pre > MAX_SYNC) pre = MAX_SYNC;
      if (pre > hist) pre = hist;
      send_block(v, k[0], low, gv, got);
      hist = (hist + BLK > MAX_SYNC) ? MAX_SYNC : hist + BLK;
      check(low == pre + 9, "R4 R5 busy cycles", low, pre + 9);
      check(gv == 1'b1, "R4 beat when ready returns", int'(gv), 1);
      if (v.h1 == 0 && v.h2 == 0)
        check(got == v.codes, "R1 R2 R6 sliced block", int'(got), int'(v.codes));
      else
        check(got == v.codes, "R1 R3 ISI block", int'(got), int'(v.codes));
    end

    // R9: output held while idle
    held = dec_syms;
    repeat (6) @(negedge clk);
    check(dec_syms == held, "R9 decisions held", int'(dec_syms), int'(held));
    check(dec_valid == 1'b0, "R9 no stray beat", int'(dec_valid), 0);

    // R7: full-scale samples with the longest prefix
    for (int k = 0; k < 3; k++) begin
      v = '{20, 0, 0, 24, 0, (k == 1) ? 16'h0000 : 16'hAAAA};
      send_block(v, 1'b0, low, gv, got);
      hist = (hist + BLK > MAX_SYNC) ? MAX_SYNC : hist + BLK;
    end
    check(got == 16'hAAAA, "R7 full-scale decisions", int'(got), 16'hAAAA);
    check(low == 33, "R7 R5 saturated prefix", low, 33);

    // R8: reset mid-block clears collection and history
    @(negedge clk);
    tap_h0 = 6'sd8; tap_h1 = '0; tap_h2 = '0;
    for (int i = 0; i < 4; i++) begin
      smp_valid = 1'b1; smp_data = 8'sd24;
      @(posedge clk);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    do_reset();
    @(negedge clk);
    check(smp_ready == 1'b1, "R8 ready after mid-block reset", int'(smp_ready), 1);
    check(dec_syms == '0, "R8 dec_syms cleared", int'(dec_syms), 0);
    v = '{8, 0, 0, 10, 2, 16'h3C96};
    send_block(v, 1'b0, low, gv, got);
    check(low == 9, "R5 R8 history cleared by reset", low, 9);
    check(got == 16'h3C96, "R1 R2 block after reset", int'(got), 16'h3C96);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule